// File: doc/BRIEF.md
# Add-With-Carry Arithmetic Unit with Status Flags

This block is the adder slice of a 16-bit microcontroller datapath. It takes a source and a destination operand, an operation select (plain add, add with carry, or no arithmetic), a byte/word width select and the four incoming status flags. It returns the sum together with freshly computed carry, zero, negative and overflow flags, plus a strobe telling the datapath that the status register should be rewritten.

In byte mode only the low eight bits of each operand take part in the addition. The upper result byte is forced to zero, and every flag is derived at 8-bit width. The plain add ignores the incoming carry; the carry variant adds it in as the least significant bit. The arithmetic itself is combinational. A one-stage output register captures the result and flags whenever an operation is presented, so the unit can be exercised cycle by cycle.

Top module: `addc_unit`

## Requirements
- R1: With `op` = 2'b01 (plain add), word-mode `res_q` equals (`src` + `dst`) mod 2^16, whatever the value of `flags_in[0]`.
- R2: With `op` = 2'b10 (add with carry), the carry-in `flags_in[0]` is added as the least significant bit of the sum.
- R3: In word mode, carry flag `flags_q[0]` is bit 16 of the unsigned 17-bit sum, and that bit is not part of `res_q`.
- R4: With `byte_mode` = 1, only bits 7:0 of both operands are added, `res_q[15:8]` is zero, and `flags_q[0]` is bit 8 of the 9-bit sum.
- R5: Zero flag `flags_q[1]` is 1 exactly when the result at the active width is zero.
- R6: Negative flag `flags_q[2]` copies the result's sign bit at the active width: bit 15 in word mode, bit 7 in byte mode.
- R7: Overflow flag `flags_q[3]` is 1 exactly when both operands have the same sign at the active width and the result's sign differs from it.
- R8: With `op` = 2'b00 or 2'b11, `res_q` equals `dst`, `flags_q` equals `flags_in`, and `flag_we_q` is 0. For the two arithmetic codes `flag_we_q` is 1.
- R9: Outputs are registered. A cycle with `in_valid` high updates them at the next rising edge and sets `out_valid`. A cycle with `in_valid` low holds `res_q`, `flags_q` and `flag_we_q`, and clears `out_valid`. A synchronous reset (`rst_n` low) clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 2 | 01 add, 10 add with carry, 00/11 pass destination |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| flags_in | input | 4 | Current flags {V,N,Z,C}, C at bit 0 |
| res_q | output | 16 | Registered result |
| flags_q | output | 4 | Registered flags {V,N,Z,C} |
| flag_we_q | output | 1 | Status register should be updated |
| out_valid | output | 1 | Outputs were loaded on the last edge |

## Verification
Operand pairs are chosen to drive each flag on its own and in pairs: unsigned wrap without signed overflow, signed overflow with and without carry, an exact zero, and a negative result with no overflow. The same pairs run in both widths, with non-zero upper bytes in byte mode, so masking errors and flags taken from the wrong bit show up. Plain add and add with carry are each run with the incoming carry set and clear, which tells apart a carry that is wrongly used from one that is wrongly dropped. The pass-through codes run with distinctive flag patterns to show that the flags come back unchanged and that no write strobe is raised.

// File: rtl/addc_pkg.sv
// Package: shared operation codes and flag bit positions for the adder slice.
// Assumes the flag vector is packed {V,N,Z,C} with carry at bit 0.
package addc_pkg;
    typedef enum logic [1:0] {
        OP_PASS0 = 2'b00,
        OP_ADD   = 2'b01,
        OP_ADDC  = 2'b10,
        OP_PASS3 = 2'b11
    } addc_op_e;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_W = 4;
endpackage

// File: rtl/addc_opnd_prep.sv
// Operand preparation: masks operands to the active width and selects the
// carry-in. Assumes BW < DW; the bits above BW are cleared in byte mode.
module addc_opnd_prep
    import addc_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic [1:0]    op,
    input  logic          byte_mode,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic          carry_flag,
    output logic [DW-1:0] opa,
    output logic [DW-1:0] opb,
    output logic          cin,
    output logic          is_arith
);
    localparam logic [DW-1:0] LO_MASK = {{(DW-BW){1'b0}}, {BW{1'b1}}};

    logic [DW-1:0] width_mask;

    // Pick the mask for the active operand width.
    always_comb begin
        width_mask = byte_mode ? LO_MASK : {DW{1'b1}};
    end

    // Mask operands, decode the operation and choose the carry-in.
    always_comb begin
        opa      = src & width_mask;
        opb      = dst & width_mask;
        is_arith = (op == OP_ADD) || (op == OP_ADDC);
        cin      = (op == OP_ADDC) ? carry_flag : 1'b0;
    end
endmodule

// File: rtl/addc_core_sum.sv
// Core adder: unsigned sum of two DW-bit operands and a carry-in, one bit
// wider than the operands. Assumes the caller masks the operands.
module addc_core_sum #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          cin,
    output logic [DW:0]   sum
);
    // Form the widened sum including the carry-in.
    always_comb begin
        sum = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cin};
    end
endmodule

// File: rtl/addc_flag_gen.sv
// Flag generator: derives the result and the C/Z/N/V flags at the active
// width, or passes the destination and incoming flags when no arithmetic
// is selected. Assumes operands above BW are already zero in byte mode.
module addc_flag_gen
    import addc_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic [DW:0]      sum,
    input  logic [DW-1:0]    opa,
    input  logic [DW-1:0]    opb,
    input  logic [DW-1:0]    dst,
    input  logic             byte_mode,
    input  logic             is_arith,
    input  logic [FLG_W-1:0] flags_in,
    output logic [DW-1:0]    result,
    output logic [FLG_W-1:0] flags,
    output logic             flag_we
);
    localparam logic [DW-1:0] LO_MASK = {{(DW-BW){1'b0}}, {BW{1'b1}}};

    logic [DW-1:0] sum_w;
    logic          c_out;
    logic          sa;
    logic          sb;
    logic          sr;

    // Select the width-appropriate result, carry and sign bits.
    always_comb begin
        if (byte_mode) begin
            sum_w = sum[DW-1:0] & LO_MASK;
            c_out = sum[BW];
            sa    = opa[BW-1];
            sb    = opb[BW-1];
            sr    = sum[BW-1];
        end else begin
            sum_w = sum[DW-1:0];
            c_out = sum[DW];
            sa    = opa[DW-1];
            sb    = opb[DW-1];
            sr    = sum[DW-1];
        end
    end

    // Build the outputs, or pass through for non-arithmetic codes.
    always_comb begin
        if (is_arith) begin
            result       = sum_w;
            flags[FLG_C] = c_out;
            flags[FLG_Z] = (sum_w == '0);
            flags[FLG_N] = sr;
            flags[FLG_V] = (sa == sb) && (sr != sa);
            flag_we      = 1'b1;
        end else begin
            result  = dst;
            flags   = flags_in;
            flag_we = 1'b0;
        end
    end
endmodule

// File: rtl/addc_unit.sv
// Top: add-with-carry arithmetic unit with a one-stage output register.
// Loads result and flags on each cycle with in_valid high; holds otherwise.
// Assumes a synchronous active-low reset.
module addc_unit
    import addc_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic             byte_mode,
    input  logic [DW-1:0]    src,
    input  logic [DW-1:0]    dst,
    input  logic [FLG_W-1:0] flags_in,
    output logic [DW-1:0]    res_q,
    output logic [FLG_W-1:0] flags_q,
    output logic             flag_we_q,
    output logic             out_valid
);
    logic [DW-1:0]    opa;
    logic [DW-1:0]    opb;
    logic             cin;
    logic             is_arith;
    logic [DW:0]      sum;
    logic [DW-1:0]    result;
    logic [FLG_W-1:0] flags;
    logic             flag_we;

    addc_opnd_prep #(.DW(DW), .BW(BW)) u_prep (
        .op         (op),
        .byte_mode  (byte_mode),
        .src        (src),
        .dst        (dst),
        .carry_flag (flags_in[FLG_C]),
        .opa        (opa),
        .opb        (opb),
        .cin        (cin),
        .is_arith   (is_arith)
    );

    addc_core_sum #(.DW(DW)) u_sum (
        .opa (opa),
        .opb (opb),
        .cin (cin),
        .sum (sum)
    );

    addc_flag_gen #(.DW(DW), .BW(BW)) u_flags (
        .sum       (sum),
        .opa       (opa),
        .opb       (opb),
        .dst       (dst),
        .byte_mode (byte_mode),
        .is_arith  (is_arith),
        .flags_in  (flags_in),
        .result    (result),
        .flags     (flags),
        .flag_we   (flag_we)
    );

    // Capture the combinational outputs when an operation is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            flags_q   <= '0;
            flag_we_q <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q     <= result;
                flags_q   <= flags;
                flag_we_q <= flag_we;
            end
        end
    end
endmodule

// File: rtl/addc_unit_chk.sv
// Checker: temporal properties on the ports of addc_unit, bound below.
// Assumes the flag packing {V,N,Z,C} and the op codes of addc_pkg.
module addc_unit_chk
    import addc_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       op,
    input logic             byte_mode,
    input logic [DW-1:0]    src,
    input logic [DW-1:0]    dst,
    input logic [FLG_W-1:0] flags_in,
    input logic [DW-1:0]    res_q,
    input logic [FLG_W-1:0] flags_q,
    input logic             flag_we_q,
    input logic             out_valid
);
    logic arith_in;
    assign arith_in = (op == OP_ADD) || (op == OP_ADDC);

    // R1: word-mode plain add gives the truncated sum, carry-in unused.
    a_r1_add_word: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == OP_ADD && !byte_mode
        |=> res_q == DW'($past(src) + $past(dst)));

    // R4: byte mode clears the upper result byte.
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && arith_in && byte_mode |=> res_q[DW-1:BW] == '0);

    // R5: zero flag matches the registered result.
    a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && arith_in |=> flags_q[FLG_Z] == (res_q == '0));

    // R6: negative flag matches the sign bit at the active width.
    a_r6_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && arith_in
        |=> flags_q[FLG_N] == ($past(byte_mode) ? res_q[BW-1] : res_q[DW-1]));

    // R8: pass-through codes return dst and incoming flags, no strobe.
    a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !arith_in
        |=> res_q == $past(dst) && flags_q == $past(flags_in) && !flag_we_q);

    // R8: arithmetic codes raise the write strobe.
    a_r8_we: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && arith_in |=> flag_we_q);

    // R9: idle cycles hold the registered outputs.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_q) && $stable(flags_q) && !out_valid);

    // R9: reset clears the outputs.
    a_r9_reset: assert property (@(posedge clk)
        !rst_n |=> res_q == '0 && flags_q == '0 && !flag_we_q && !out_valid);
endmodule

bind addc_unit addc_unit_chk #(.DW(DW), .BW(BW)) u_chk (.*);

// File: tb/sim_addc_unit.sv
// Bench: table-driven vectors, then directed checks on hold and reset.
module sim_addc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        byte_mode = 1'b0;
    logic [15:0] src = '0;
    logic [15:0] dst = '0;
    logic [3:0]  flags_in = '0;
    logic [15:0] res_q;
    logic [3:0]  flags_q;
    logic        flag_we_q;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    addc_unit u0 (.*);

    // {op, byte, src, dst, flags_in, exp_res, exp_flags{V,N,Z,C}, exp_we}
    localparam int NV = 25;
    localparam logic [59:0] VEC [NV] = '{
        {2'd1, 1'b0, 16'h4444, 16'h5555, 4'h0, 16'h9999, 4'b1100, 1'b1},
        {2'd1, 1'b0, 16'h6666, 16'h7777, 4'h1, 16'hDDDD, 4'b1100, 1'b1},
        {2'd2, 1'b0, 16'h8888, 16'h9999, 4'h0, 16'h2221, 4'b1001, 1'b1},
        {2'd2, 1'b0, 16'hAAAA, 16'hBBBB, 4'h1, 16'h6666, 4'b1001, 1'b1},
        {2'd1, 1'b1, 16'h4444, 16'h5555, 4'h0, 16'h0099, 4'b1100, 1'b1},
        {2'd1, 1'b1, 16'h6666, 16'h6677, 4'h1, 16'h00DD, 4'b1100, 1'b1},
        {2'd2, 1'b1, 16'h8888, 16'h9999, 4'h0, 16'h0021, 4'b1001, 1'b1},
        {2'd2, 1'b1, 16'hAAAA, 16'hBBBB, 4'h1, 16'h0066, 4'b1001, 1'b1},
        {2'd2, 1'b0, 16'h0444, 16'h0555, 4'h0, 16'h0999, 4'b0000, 1'b1},
        {2'd2, 1'b0, 16'h0011, 16'hFFF0, 4'h0, 16'h0001, 4'b0001, 1'b1},
        {2'd2, 1'b0, 16'h0000, 16'h0000, 4'h0, 16'h0000, 4'b0010, 1'b1},
        {2'd2, 1'b0, 16'hFF00, 16'h0010, 4'h0, 16'hFF10, 4'b0100, 1'b1},
        {2'd2, 1'b0, 16'h7FFF, 16'h0010, 4'h0, 16'h800F, 4'b1100, 1'b1},
        {2'd2, 1'b0, 16'hFF00, 16'h8000, 4'h0, 16'h7F00, 4'b1001, 1'b1},
        {2'd2, 1'b1, 16'hAA04, 16'h6605, 4'h0, 16'h0009, 4'b0000, 1'b1},
        {2'd2, 1'b1, 16'hAA11, 16'h66F0, 4'h0, 16'h0001, 4'b0001, 1'b1},
        {2'd2, 1'b1, 16'hAA00, 16'h6600, 4'h0, 16'h0000, 4'b0010, 1'b1},
        {2'd2, 1'b1, 16'hAAF0, 16'h6603, 4'h0, 16'h00F3, 4'b0100, 1'b1},
        {2'd2, 1'b1, 16'h007F, 16'h0010, 4'h0, 16'h008F, 4'b1100, 1'b1},
        {2'd2, 1'b1, 16'h00FF, 16'h0080, 4'h0, 16'h007F, 4'b1001, 1'b1},
        {2'd0, 1'b0, 16'h1234, 16'hABCD, 4'hA, 16'hABCD, 4'b1010, 1'b0},
        {2'd3, 1'b1, 16'hFFFF, 16'h0000, 4'h5, 16'h0000, 4'b0101, 1'b0},
        {2'd2, 1'b0, 16'hFFFF, 16'h0000, 4'h1, 16'h0000, 4'b0011, 1'b1},
        {2'd2, 1'b1, 16'hFFFF, 16'hFF00, 4'h1, 16'h0000, 4'b0011, 1'b1},
        {2'd1, 1'b0, 16'h0001, 16'h0001, 4'hF, 16'h0002, 4'b0000, 1'b1}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Tag for the result check of a vector: which requirement it shows.
    function automatic string res_tag(input logic [1:0] o, input logic b);
        if (o == 2'd0 || o == 2'd3) return "R8 result";
        if (b) return "R4 result";
        if (o == 2'd1) return "R1 result";
        return "R2 result";
    endfunction

    task automatic apply(input logic [59:0] v);
        @(negedge clk);
        op        = v[59:58];
        byte_mode = v[57];
        src       = v[56:41];
        dst       = v[40:25];
        flags_in  = v[24:21];
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: reset state.
        check("R9 reset res", res_q, 16'h0000);
        check("R9 reset flags", {12'h0, flags_q}, 16'h0000);
        check("R9 reset valid", {15'h0, out_valid}, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [59:0] v;
            v = VEC[i];
            apply(v);
            check(res_tag(v[59:58], v[57]), res_q, v[20:5]);
            // Carry from bit 16 (R3) or bit 8 (R4), or passed through (R8).
            check(v[57] ? "R4 carry" : "R3 carry", {15'h0, flags_q[0]}, {15'h0, v[1]});
            check("R5 zero", {15'h0, flags_q[1]}, {15'h0, v[2]});
            check("R6 negative", {15'h0, flags_q[2]}, {15'h0, v[3]});
            check("R7 overflow", {15'h0, flags_q[3]}, {15'h0, v[4]});
            check("R8 write strobe", {15'h0, flag_we_q}, {15'h0, v[0]});
            check("R9 valid", {15'h0, out_valid}, 16'h0001);
        end

        // R9: with in_valid low, changed inputs leave the outputs unchanged.
        apply(VEC[12]);
        @(negedge clk);
        op = 2'd1; src = 16'h1111; dst = 16'h2222; flags_in = 4'h0;
        @(negedge clk);
        check("R9 hold res", res_q, 16'h800F);
        check("R9 hold flags", {12'h0, flags_q}, 16'h000C);
        check("R9 valid low", {15'h0, out_valid}, 16'h0000);

        // R9: reset after activity clears everything again.
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 re-reset res", res_q, 16'h0000);
        check("R9 re-reset we", {15'h0, flag_we_q}, 16'h0000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule